// File: doc/BRIEF.md
# UART Receive/Transmit Data Register Stage

This block sits between a processor bus and the serial engines of one UART channel. It holds the most recent character delivered by the receive shift register, keeps the byte waiting to be sent, and tracks the flags software needs to move data safely. Reads and writes both reach the data through one shared bus address. A read returns the received byte. A write at the same address loads the transmit byte.

When a character arrives, the block stores it and raises a receive-full flag. A level-sensitive interrupt request follows that flag when it is enabled. Reading the data register clears the flag as a side effect. Parity, framing and overrun errors are kept as sticky flags in a status register that is readable beside the data. While any of these flags is set, the status register also marks the stored data as invalid. An explicit write clears all error flags. A short-character mode masks the top data bit so that reads are deterministic. The receive and transmit engines are represented by plain strobes: one delivers a character together with its error indications, and one takes the transmit byte.

Top module: `uart_dreg`

## Requirements
- R1: After reset the receive byte and transmit byte are 0, rx_full is 0, tx_empty is 1, rx_irq is 0, every error flag is 0, and the control register reads 0.
- R2: Address 0 is shared. bus_rdata at address 0 shows the stored receive byte, and a bus_wr at address 0 loads bus_wdata into the transmit byte (tx_data) on the next clock.
- R3: A cycle with rx_strobe high, arriving while rx_full is 0 (or while that data is being read), stores rx_byte and sets rx_full on the next clock.
- R4: rx_irq is high exactly when rx_full is 1 and the enable bit (control register bit 0, written at address 2) is 1.
- R5: A bus_rd at address 0 without a new arrival in the same cycle clears rx_full on the next clock. A read of any other address leaves rx_full unchanged.
- R6: With the short-character bit set (control bit 1), bit 7 of a stored byte is forced to 0. With the bit clear, all 8 bits are stored.
- R7: rx_perr and rx_ferr set sticky flags on any arrival. The status register at address 1 reads bit0 rx_full, bit1 tx_empty, bit2 parity error, bit3 overrun, bit4 framing error, and bit5 data-invalid (the OR of the three error flags, also on rx_bad). Bits 7:6 read 0.
- R8: An arrival while rx_full is 1 and no data read happens in the same cycle sets the overrun flag and keeps the old byte.
- R9: A bus_wr at address 3 clears all three error flags. Errors that arrive in the same cycle are still recorded. Address 3 reads 0.
- R10: A write to address 0 clears tx_empty. A tx_take pulse sets tx_empty again. tx_take while tx_empty is already 1 changes nothing.
- R11: An arrival in the same cycle as a data read takes priority: rx_full stays 1, the new byte is stored, and no overrun is recorded.
- R12: A transmit write in the same cycle as tx_take takes priority: tx_empty ends at 0 and tx_data holds the new byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 data, 1 status, 2 control, 3 error clear |
| bus_rd | input | 1 | Read strobe; at address 0 it consumes the received byte |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for the selected register |
| rx_strobe | input | 1 | Receive engine delivers a character |
| rx_byte | input | 8 | Delivered character |
| rx_perr | input | 1 | Parity error attached to the delivery |
| rx_ferr | input | 1 | Framing error attached to the delivery |
| tx_take | input | 1 | Transmit engine takes the held byte |
| tx_data | output | 8 | Transmit holding byte |
| tx_empty | output | 1 | Transmit holding register is free |
| rx_full | output | 1 | Receive data waiting |
| rx_irq | output | 1 | Receive interrupt request (level) |
| rx_bad | output | 1 | Stored data is invalid because an error flag is set |

## Verification
The bench targets the collisions at the receive side. A read in the same cycle as an arrival must keep the flag set with the new byte. A design that let the read win would drop that character, or would record a false overrun. An arrival on a full buffer must leave the old byte in place, so a design that overwrote it would show the new byte at address 0. The bench also checks the case where a transmit write and a take land together, which must leave the holding register occupied. It checks that the short-character mask is taken from the mode in force when the byte arrives. It checks that an error clear does not swallow an error arriving in the same cycle. Finally, it checks that the interrupt follows the enable bit while data is already waiting.

// File: rtl/uart_dreg_pkg.sv
package uart_dreg_pkg;

    localparam int REG_ADDR_W = 2;

    typedef enum logic [REG_ADDR_W-1:0] {
        SEL_DATA = 2'd0,
        SEL_STAT = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_ECLR = 2'd3
    } reg_sel_e;

    // status bit positions
    localparam int ST_FULL = 0;
    localparam int ST_TXE  = 1;
    localparam int ST_PERR = 2;
    localparam int ST_OVR  = 3;
    localparam int ST_FERR = 4;
    localparam int ST_BAD  = 5;

    // control bit positions
    localparam int CT_IE    = 0;
    localparam int CT_SHORT = 1;
    localparam int CT_W     = 2;

endpackage

// File: rtl/uart_dreg_busdec.sv
module uart_dreg_busdec
    import uart_dreg_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [REG_ADDR_W-1:0] bus_addr_i,
    input  logic                  bus_rd_i,
    input  logic                  bus_wr_i,
    input  logic [DATA_W-1:0]     rx_data_i,
    input  logic                  rx_full_i,
    input  logic                  tx_empty_i,
    input  logic                  perr_i,
    input  logic                  ovr_i,
    input  logic                  ferr_i,
    input  logic [CT_W-1:0]       ctrl_i,
    output logic                  rd_data_o,
    output logic                  wr_data_o,
    output logic                  wr_ctrl_o,
    output logic                  wr_eclr_o,
    output logic [DATA_W-1:0]     rdata_o
);

    reg_sel_e           sel;
    logic [DATA_W-1:0]  stat_view;
    logic [DATA_W-1:0]  ctrl_view;

    assign sel = reg_sel_e'(bus_addr_i);

    always_comb begin
        stat_view           = '0;
        stat_view[ST_FULL]  = rx_full_i;
        stat_view[ST_TXE]   = tx_empty_i;
        stat_view[ST_PERR]  = perr_i;
        stat_view[ST_OVR]   = ovr_i;
        stat_view[ST_FERR]  = ferr_i;
        stat_view[ST_BAD]   = perr_i | ovr_i | ferr_i;
        ctrl_view           = '0;
        ctrl_view[CT_W-1:0] = ctrl_i;
    end

    always_comb begin
        rd_data_o = 1'b0;
        wr_data_o = 1'b0;
        wr_ctrl_o = 1'b0;
        wr_eclr_o = 1'b0;
        rdata_o   = '0;
        unique case (sel)
            SEL_DATA: begin
                rdata_o   = rx_data_i;
                rd_data_o = bus_rd_i;
                wr_data_o = bus_wr_i;
            end
            SEL_STAT: rdata_o = stat_view;
            SEL_CTRL: begin
                rdata_o   = ctrl_view;
                wr_ctrl_o = bus_wr_i;
            end
            SEL_ECLR: wr_eclr_o = bus_wr_i;
            default:  rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/uart_dreg_ctrl.sv
module uart_dreg_ctrl
    import uart_dreg_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_i,
    input  logic [CT_W-1:0] wdata_i,
    output logic            ie_o,
    output logic            short_o,
    output logic [CT_W-1:0] ctrl_o
);

    typedef struct packed {
        logic ie;
        logic short_mode;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            st_d.ie         = wdata_i[CT_IE];
            st_d.short_mode = wdata_i[CT_SHORT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ie_o    = st_q.ie;
    assign short_o = st_q.short_mode;

    always_comb begin
        ctrl_o           = '0;
        ctrl_o[CT_IE]    = st_q.ie;
        ctrl_o[CT_SHORT] = st_q.short_mode;
    end

endmodule

// File: rtl/uart_dreg_rx.sv
module uart_dreg_rx #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_strobe_i,
    input  logic [DATA_W-1:0] rx_byte_i,
    input  logic              rx_perr_i,
    input  logic              rx_ferr_i,
    input  logic              short_i,
    input  logic              rd_clr_i,
    input  logic              err_clr_i,
    output logic [DATA_W-1:0] data_o,
    output logic              full_o,
    output logic              perr_o,
    output logic              ovr_o,
    output logic              ferr_o
);

    localparam int MSB = DATA_W - 1;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              full;
        logic              perr;
        logic              ovr;
        logic              ferr;
    } rx_state_t;

    rx_state_t         st_d, st_q;
    logic [DATA_W-1:0] shaped;
    logic              still_held;

    always_comb begin
        shaped = rx_byte_i;
        if (short_i) shaped[MSB] = 1'b0;
    end

    // the old byte survives this cycle only if nobody reads it
    assign still_held = st_q.full && !rd_clr_i;

    always_comb begin
        st_d = st_q;
        if (err_clr_i) begin
            st_d.perr = 1'b0;
            st_d.ovr  = 1'b0;
            st_d.ferr = 1'b0;
        end
        if (rx_strobe_i) begin
            st_d.perr = st_d.perr | rx_perr_i;
            st_d.ferr = st_d.ferr | rx_ferr_i;
            if (still_held) begin
                st_d.ovr = 1'b1;
            end else begin
                st_d.data = shaped;
                st_d.full = 1'b1;
            end
        end else if (rd_clr_i) begin
            st_d.full = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data_o = st_q.data;
    assign full_o = st_q.full;
    assign perr_o = st_q.perr;
    assign ovr_o  = st_q.ovr;
    assign ferr_o = st_q.ferr;

    assert_arrival_sets_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_strobe_i |=> full_o);

    assert_read_clears_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr_i && !rx_strobe_i) |=> !full_o);

    assert_short_masks_msb_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_strobe_i && short_i && !(full_o && !rd_clr_i)) |=> !data_o[MSB]);

    assert_overrun_keeps_old_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_strobe_i && full_o && !rd_clr_i) |=> (ovr_o && $stable(data_o)));

    assert_err_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr_i && !rx_strobe_i) |=> (!perr_o && !ovr_o && !ferr_o));

    assert_arrival_beats_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_strobe_i && rd_clr_i && !err_clr_i) |=> (full_o && ovr_o == $past(ovr_o)));

endmodule

// File: rtl/uart_dreg_tx.sv
module uart_dreg_tx #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              take_i,
    output logic [DATA_W-1:0] data_o,
    output logic              empty_o
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              empty;
    } tx_state_t;

    localparam tx_state_t TX_RST = '{data: '0, empty: 1'b1};

    tx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            st_d.data  = wdata_i;
            st_d.empty = 1'b0;
        end else if (take_i) begin
            st_d.empty = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= TX_RST;
        else        st_q <= st_d;
    end

    assign data_o  = st_q.data;
    assign empty_o = st_q.empty;

    assert_take_frees_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && !wr_i) |=> empty_o);

    assert_write_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (!empty_o && data_o == $past(wdata_i)));

endmodule

// File: rtl/uart_dreg.sv
module uart_dreg
    import uart_dreg_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic                  bus_rd,
    input  logic                  bus_wr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    input  logic                  rx_strobe,
    input  logic [DATA_W-1:0]     rx_byte,
    input  logic                  rx_perr,
    input  logic                  rx_ferr,
    input  logic                  tx_take,
    output logic [DATA_W-1:0]     tx_data,
    output logic                  tx_empty,
    output logic                  rx_full,
    output logic                  rx_irq,
    output logic                  rx_bad
);

    logic              rd_data, wr_data, wr_ctrl, wr_eclr;
    logic              ie, short_mode;
    logic [CT_W-1:0]   ctrl_bits;
    logic [DATA_W-1:0] rx_data;
    logic              perr, ovr, ferr;

    uart_dreg_busdec #(.DATA_W(DATA_W)) u_dec (
        .bus_addr_i (bus_addr),
        .bus_rd_i   (bus_rd),
        .bus_wr_i   (bus_wr),
        .rx_data_i  (rx_data),
        .rx_full_i  (rx_full),
        .tx_empty_i (tx_empty),
        .perr_i     (perr),
        .ovr_i      (ovr),
        .ferr_i     (ferr),
        .ctrl_i     (ctrl_bits),
        .rd_data_o  (rd_data),
        .wr_data_o  (wr_data),
        .wr_ctrl_o  (wr_ctrl),
        .wr_eclr_o  (wr_eclr),
        .rdata_o    (bus_rdata)
    );

    uart_dreg_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (wr_ctrl),
        .wdata_i (bus_wdata[CT_W-1:0]),
        .ie_o    (ie),
        .short_o (short_mode),
        .ctrl_o  (ctrl_bits)
    );

    uart_dreg_rx #(.DATA_W(DATA_W)) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_strobe_i (rx_strobe),
        .rx_byte_i   (rx_byte),
        .rx_perr_i   (rx_perr),
        .rx_ferr_i   (rx_ferr),
        .short_i     (short_mode),
        .rd_clr_i    (rd_data),
        .err_clr_i   (wr_eclr),
        .data_o      (rx_data),
        .full_o      (rx_full),
        .perr_o      (perr),
        .ovr_o       (ovr),
        .ferr_o      (ferr)
    );

    uart_dreg_tx #(.DATA_W(DATA_W)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (wr_data),
        .wdata_i (bus_wdata),
        .take_i  (tx_take),
        .data_o  (tx_data),
        .empty_o (tx_empty)
    );

    assign rx_irq = rx_full & ie;
    assign rx_bad = perr | ovr | ferr;

    assert_irq_needs_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> rx_full);

    assert_irq_drops_on_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == SEL_DATA && !rx_strobe) |=> !rx_irq);

endmodule

// File: tb/sim_uart_dreg.sv
module sim_uart_dreg;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       rx_strobe = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       rx_perr = 1'b0, rx_ferr = 1'b0, tx_take = 1'b0;
    logic [7:0] tx_data;
    logic       tx_empty, rx_full, rx_irq, rx_bad;

    int checks = 0;
    int fails  = 0;

    // behavioural reference state
    logic [7:0] m_rx = '0, m_tx = '0;
    logic       m_full = 0, m_empty = 1, m_pe = 0, m_oe = 0, m_fe = 0, m_ie = 0, m_short = 0;

    always #10 clk = ~clk;

    uart_dreg u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_strobe(rx_strobe), .rx_byte(rx_byte),
        .rx_perr(rx_perr), .rx_ferr(rx_ferr), .tx_take(tx_take), .tx_data(tx_data),
        .tx_empty(tx_empty), .rx_full(rx_full), .rx_irq(rx_irq), .rx_bad(rx_bad)
    );

    function automatic logic [7:0] exp_rdata(input logic [1:0] a);
        case (a)
            2'd0:    return m_rx;
            2'd1:    return {2'b00, (m_pe | m_oe | m_fe), m_fe, m_oe, m_pe, m_empty, m_full};
            2'd2:    return {6'b0, m_short, m_ie};
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic chk_outputs(input string tag);
        chk(tag, "rx_full",  {7'b0, rx_full},  {7'b0, m_full});
        chk(tag, "rx_irq",   {7'b0, rx_irq},   {7'b0, (m_full & m_ie)});
        chk(tag, "tx_empty", {7'b0, tx_empty}, {7'b0, m_empty});
        chk(tag, "tx_data",  tx_data, m_tx);
        chk(tag, "rx_bad",   {7'b0, rx_bad},   {7'b0, (m_pe | m_oe | m_fe)});
    endtask

    // one clock: drive at the falling edge, check the combinational read,
    // advance the model at the rising edge, check registered outputs at the next falling edge
    task automatic step(input string tag, input logic [1:0] a, input logic rd, input logic wr,
                        input logic [7:0] wd, input logic rs, input logic [7:0] rb,
                        input logic pe, input logic fe, input logic take);
        logic rdclr;
        logic held;
        bus_addr = a; bus_rd = rd; bus_wr = wr; bus_wdata = wd;
        rx_strobe = rs; rx_byte = rb; rx_perr = pe; rx_ferr = fe; tx_take = take;
        #1;
        chk(tag, "rdata", bus_rdata, exp_rdata(a));
        @(posedge clk);
        rdclr = rd && (a == 2'd0);
        held  = m_full && !rdclr;
        if (wr && a == 2'd3) begin m_pe = 0; m_oe = 0; m_fe = 0; end
        if (rs) begin
            m_pe = m_pe | pe;
            m_fe = m_fe | fe;
            if (held) m_oe = 1;
            else begin m_rx = m_short ? {1'b0, rb[6:0]} : rb; m_full = 1; end
        end else if (rdclr) m_full = 0;
        if (wr && a == 2'd0) begin m_tx = wd; m_empty = 0; end
        else if (take) m_empty = 1;
        if (wr && a == 2'd2) begin m_ie = wd[0]; m_short = wd[1]; end
        @(negedge clk);
        bus_rd = 0; bus_wr = 0; rx_strobe = 0; rx_perr = 0; rx_ferr = 0; tx_take = 0;
        chk_outputs(tag);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int unsigned lcg;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset values
        chk_outputs("R1");
        bus_addr = 2'd1; #1; chk("R1", "status", bus_rdata, 8'h02);
        bus_addr = 2'd2; #1; chk("R1", "ctrl",   bus_rdata, 8'h00);
        bus_addr = 2'd0; #1; chk("R1", "rxdata", bus_rdata, 8'h00);

        // R2 / R10: transmit write, take, take again while empty
        step("R2",  2'd0, 0, 1, 8'hA5, 0, 8'h00, 0, 0, 0);
        step("R10", 2'd1, 0, 0, 8'h00, 0, 8'h00, 0, 0, 1);
        step("R10", 2'd1, 0, 0, 8'h00, 0, 8'h00, 0, 0, 1);

        // R4 enable, R3 arrival, R2 read, R5 clear
        step("R4", 2'd2, 0, 1, 8'h01, 0, 8'h00, 0, 0, 0);
        step("R3", 2'd1, 0, 0, 8'h00, 1, 8'h3C, 0, 0, 0);
        step("R5", 2'd1, 1, 0, 8'h00, 0, 8'h00, 0, 0, 0);
        step("R2", 2'd0, 1, 0, 8'h00, 0, 8'h00, 0, 0, 0);

        // R6 short mode masks bit 7, then full width
        step("R6", 2'd2, 0, 1, 8'h03, 0, 8'h00, 0, 0, 0);
        step("R6", 2'd0, 0, 0, 8'h00, 1, 8'hFF, 0, 0, 0);
        step("R6", 2'd0, 1, 0, 8'h00, 0, 8'h00, 0, 0, 0);
        step("R6", 2'd2, 0, 1, 8'h01, 0, 8'h00, 0, 0, 0);
        step("R6", 2'd0, 0, 0, 8'h00, 1, 8'h81, 0, 0, 0);

        // R8 overrun keeps old byte, R7 status view
        step("R8", 2'd0, 0, 0, 8'h00, 1, 8'h22, 0, 0, 0);
        step("R7", 2'd1, 0, 0, 8'h00, 0, 8'h00, 0, 0, 0);
        step("R8", 2'd0, 0, 0, 8'h00, 0, 8'h00, 0, 0, 0);

        // R9 clear errors
        step("R9", 2'd3, 0, 1, 8'hFF, 0, 8'h00, 0, 0, 0);
        step("R9", 2'd3, 0, 0, 8'h00, 0, 8'h00, 0, 0, 0);

        // R11 arrival in the same cycle as the data read
        step("R11", 2'd0, 1, 0, 8'h00, 1, 8'h55, 0, 0, 0);
        step("R11", 2'd1, 0, 0, 8'h00, 0, 8'h00, 0, 0, 0);
        step("R11", 2'd0, 1, 0, 8'h00, 0, 8'h00, 0, 0, 0);

        // R7 parity and framing flags, R9 clear racing a new error
        step("R7", 2'd1, 0, 0, 8'h00, 1, 8'h10, 1, 0, 0);
        step("R7", 2'd0, 1, 0, 8'h00, 1, 8'h20, 0, 1, 0);
        step("R7", 2'd1, 0, 0, 8'h00, 0, 8'h00, 0, 0, 0);
        step("R9", 2'd3, 0, 1, 8'h00, 1, 8'h30, 1, 0, 0);
        step("R9", 2'd1, 0, 0, 8'h00, 0, 8'h00, 0, 0, 0);
        step("R9", 2'd3, 0, 1, 8'h00, 0, 8'h00, 0, 0, 0);

        // R12 write and take together
        step("R12", 2'd0, 0, 1, 8'h5A, 0, 8'h00, 0, 0, 1);
        step("R12", 2'd1, 0, 0, 8'h00, 0, 8'h00, 0, 0, 0);

        // R4 interrupt follows enable while data waits
        step("R4", 2'd2, 0, 1, 8'h00, 0, 8'h00, 0, 0, 0);
        step("R4", 2'd2, 0, 1, 8'h01, 0, 8'h00, 0, 0, 0);
        step("R5", 2'd1, 1, 0, 8'h00, 0, 8'h00, 0, 0, 0);
        step("R5", 2'd0, 1, 0, 8'h00, 0, 8'h00, 0, 0, 0);

        // mixed traffic against the model
        lcg = 32'h1234_5678;
        for (int i = 0; i < 400; i++) begin
            logic [1:0] a;
            logic [7:0] d;
            lcg = lcg * 32'd1103515245 + 32'd12345;
            a = lcg[17:16];
            d = lcg[31:24];
            step("R3", a, lcg[18], lcg[19] & lcg[20], d, lcg[21] & lcg[22], d ^ 8'h5C,
                 lcg[23] & lcg[10], lcg[11] & lcg[12], lcg[13]);
        end

        finish_run();
    end

endmodule